// File: doc/BRIEF.md
# Shared PWM Waveform Generator Bank

This block holds a small pool of slow waveform generators that a larger set of output pins borrow from. Each generator owns a period setting and a duty setting made of two step counts: how many steps its output stays high and how many it then stays low. A pin owns no timer at all. It carries a 4-bit map entry that names one generator and gates the pin on or off. Several pins can therefore show the same waveform, and no more than eight different period/duty pairs can run at once.

Software drives the bank through a word-wide write/read port that holds three groups of 32-bit words: period words, duty words and pin map words. A free-running prescaler makes a base tick that stands for 1/255 of 4 ms. A generator with period value P advances one step every P base ticks, so one step lasts P × 4 ms / 255. The generator outputs are also brought out raw for other consumers. New period or duty values wait for the running period to end. Changing a pin's generator selection acts at once. Turning a pin off waits for the selected generator's period boundary, so the pin is never cut mid-pulse.

Top module: `pwm_gen_bank`

## Requirements
- R1: After reset every register word reads 0, every pin output is low and every generator output is low.
- R2: A word written through the register port reads back unchanged at the same address. Word addresses are: 0-1 period words, 2-5 duty words, 6-7 map words.
- R3: A running generator with period value P, high count H and low count L repeats a waveform that is high for H×P base ticks and then low for L×P base ticks.
- R4: Period values above 250 behave exactly like 250.
- R5: High count 0 gives a constant-low generator output. Low count 0 with a nonzero high count gives a constant-high output.
- R6: A generator whose period value is 0, or whose high and low counts are both 0, is idle and its output is low.
- R7: New period or duty values for a running generator are not used until its current period ends. At that boundary all three values are taken together.
- R8: A pin whose map enable is set drives the output of the generator its ID selects. A change of ID or the setting of the enable takes effect in the first cycle after the write.
- R9: A pin whose map enable is cleared keeps following its generator until that generator's next period boundary, and is low from then on. A pin whose enable was never set stays low.
- R10: Field layout: generator g's period byte sits in word g/4 at bits 8×(g%4)+7..8×(g%4). Its duty field sits in word 2+g/2 at bits 16×(g%2)+15..16×(g%2), with the high count in the low byte and the low count in the high byte. Pin p's map nibble sits in word 6+p/8 at bits 4×(p%8)+3..4×(p%8), with the generator ID in nibble bits 2..0 and the enable in nibble bit 3.
- R11: Any number of pins may select the same generator, and they then show the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_out | output | 16 | Pin outputs |
| gen_out | output | 8 | Raw generator outputs |

## Verification
The hardest states to reach are the two deferred updates: a duty rewrite and a pin disable that both land while a pulse is running. The stimulus waits for a rising edge of the chosen generator and issues the write at once. It then counts how long the pulse stays high under the old settings before the new period shape appears. For the disable, it confirms that the pin stays high right after the write and is low once the boundary has passed. Measuring waveforms from one rising edge to the next makes the high-time and period checks independent of the phase at which each generator started.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int WORD_W    = 32;
    localparam int PER_W     = 8;
    localparam int STEP_W    = 8;
    localparam int GEN_ID_W  = 3;
    localparam int PER_PER_WORD  = WORD_W / PER_W;
    localparam int DUTY_PER_WORD = WORD_W / (2 * STEP_W);
    localparam int MAP_PER_WORD  = WORD_W / (GEN_ID_W + 1);
    localparam logic [PER_W-1:0] PER_LIMIT = 8'd250;

    typedef struct packed {
        logic [STEP_W-1:0] low_steps;
        logic [STEP_W-1:0] high_steps;
    } duty_t;

    typedef struct packed {
        logic                enable;
        logic [GEN_ID_W-1:0] gen_id;
    } pin_map_t;

    function automatic logic [PER_W-1:0] clamp_period(input logic [PER_W-1:0] v);
        return (v > PER_LIMIT) ? PER_LIMIT : v;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int BASE_DIV = 3137
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BASE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !rst && (cnt_q == LAST);
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_PIN = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_GEN/PER_PER_WORD + NUM_GEN/DUTY_PER_WORD + NUM_PIN/MAP_PER_WORD)-1:0] addr,
    input  logic [WORD_W-1:0]                   wdata,
    output logic [WORD_W-1:0]                   rdata,
    output logic [NUM_GEN-1:0][PER_W-1:0]       per_val,
    output duty_t [NUM_GEN-1:0]                 duty_val,
    output pin_map_t [NUM_PIN-1:0]              pin_map
);
    localparam int PER_WORDS  = NUM_GEN / PER_PER_WORD;
    localparam int DUTY_WORDS = NUM_GEN / DUTY_PER_WORD;
    localparam int MAP_WORDS  = NUM_PIN / MAP_PER_WORD;
    localparam int NUM_WORDS  = PER_WORDS + DUTY_WORDS + MAP_WORDS;
    localparam int ADDR_W     = $clog2(NUM_WORDS);
    localparam int DUTY_BASE  = PER_WORDS;
    localparam int MAP_BASE   = PER_WORDS + DUTY_WORDS;
    localparam int MAP_NIB_W  = GEN_ID_W + 1;

    logic [WORD_W-1:0] words_q [NUM_WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rst) begin
                words_q[i] <= '0;
            end else if (wr_en && addr == ADDR_W'(i)) begin
                words_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = words_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_fields
        assign per_val[g]  = words_q[g / PER_PER_WORD][PER_W*(g % PER_PER_WORD) +: PER_W];
        assign duty_val[g] = duty_t'(words_q[DUTY_BASE + g / DUTY_PER_WORD]
                                     [2*STEP_W*(g % DUTY_PER_WORD) +: 2*STEP_W]);
    end

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin_fields
        assign pin_map[p] = pin_map_t'(words_q[MAP_BASE + p / MAP_PER_WORD]
                                       [MAP_NIB_W*(p % MAP_PER_WORD) +: MAP_NIB_W]);
    end
endmodule

// File: rtl/pwm_wavegen.sv
module pwm_wavegen
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [PER_W-1:0] per_i,
    input  duty_t            duty_i,
    output logic             out_o,
    output logic             wrap_o
);
    localparam int LEN_W = STEP_W + 1;

    logic [PER_W-1:0]  per_l;
    duty_t             duty_l;
    logic [PER_W-1:0]  sub_cnt;
    logic [LEN_W-1:0]  step_cnt;
    logic [LEN_W-1:0]  len;
    logic              active;
    logic              step_adv;
    logic              last_step;

    assign len       = {1'b0, duty_l.high_steps} + {1'b0, duty_l.low_steps};
    assign active    = (per_l != '0) && (len != '0);
    assign step_adv  = active && tick && (sub_cnt == per_l - 1'b1);
    assign last_step = (step_cnt == len - 1'b1);
    assign wrap_o    = !active || (step_adv && last_step);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_l    <= '0;
            duty_l   <= '0;
            sub_cnt  <= '0;
            step_cnt <= '0;
        end else if (wrap_o) begin
            per_l    <= clamp_period(per_i);
            duty_l   <= duty_i;
            sub_cnt  <= '0;
            step_cnt <= '0;
        end else if (tick) begin
            if (sub_cnt == per_l - 1'b1) begin
                sub_cnt  <= '0;
                step_cnt <= step_cnt + 1'b1;
            end else begin
                sub_cnt  <= sub_cnt + 1'b1;
            end
        end
    end

    assign out_o = active && (step_cnt < {1'b0, duty_l.high_steps});
endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_PIN = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pin_map_t [NUM_PIN-1:0] pin_map,
    input  logic [NUM_GEN-1:0]     gen_out,
    input  logic [NUM_GEN-1:0]     gen_wrap,
    output logic [NUM_PIN-1:0]     pin_out
);
    logic [NUM_PIN-1:0] hold_q;

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        logic [GEN_ID_W-1:0] sel;
        assign sel = pin_map[p].gen_id;

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[p] <= 1'b0;
            end else begin
                hold_q[p] <= pin_map[p].enable | (hold_q[p] & ~gen_wrap[sel]);
            end
        end

        assign pin_out[p] = (pin_map[p].enable | hold_q[p]) & gen_out[sel];
    end
endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_PIN  = 16,
    parameter int BASE_DIV = 3137,
    localparam int ADDR_W  = $clog2(NUM_GEN/PER_PER_WORD + NUM_GEN/DUTY_PER_WORD
                                    + NUM_PIN/MAP_PER_WORD)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rdata,
    output logic [NUM_PIN-1:0] pin_out,
    output logic [NUM_GEN-1:0] gen_out
);
    logic                        tick;
    logic [NUM_GEN-1:0][PER_W-1:0] per_val;
    duty_t [NUM_GEN-1:0]         duty_val;
    pin_map_t [NUM_PIN-1:0]      pin_map;
    logic [NUM_GEN-1:0]          gen_wrap;

    pwm_timebase #(.BASE_DIV(BASE_DIV)) u_timebase (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    pwm_regfile #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .per_val (per_val),
        .duty_val(duty_val),
        .pin_map (pin_map)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_wave
        pwm_wavegen u_gen (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .per_i (per_val[g]),
            .duty_i(duty_val[g]),
            .out_o (gen_out[g]),
            .wrap_o(gen_wrap[g])
        );
    end

    pwm_pin_mux #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .pin_map (pin_map),
        .gen_out (gen_out),
        .gen_wrap(gen_wrap),
        .pin_out (pin_out)
    );
endmodule

// File: rtl/pwm_gen_bank_chk.sv
module pwm_gen_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_PIN = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_PIN-1:0]     pin_out,
    input logic [NUM_GEN-1:0]     gen_out,
    input logic [NUM_GEN-1:0]     gen_wrap,
    input pin_map_t [NUM_PIN-1:0] pin_map
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_out == '0 && gen_out == '0)); // R1

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin_chk
        AST_PIN_NEEDS_GEN: assert property (@(posedge clk) disable iff (rst)
            pin_out[p] |-> gen_out[pin_map[p].gen_id]); // R8

        AST_DISABLE_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
            (!pin_map[p].enable && $past(!pin_map[p].enable) && $stable(pin_map[p].gen_id)
             && $past(gen_wrap[pin_map[p].gen_id])) |-> !pin_out[p]); // R9
    end
endmodule

module pwm_wavegen_chk
    import pwm_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PER_W-1:0]  per_l,
    input duty_t             duty_l,
    input logic [STEP_W:0]   step_cnt,
    input logic              active,
    input logic              wrap_o,
    input logic              out_o
);
    AST_PERIOD_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        per_l <= PER_LIMIT); // R4

    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (step_cnt < ({1'b0, duty_l.high_steps} + {1'b0, duty_l.low_steps}))); // R3

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(per_l) || !$stable(duty_l)) |-> $past(wrap_o)); // R7

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
        (active && duty_l.low_steps == '0) |-> out_o); // R5
endmodule

bind pwm_gen_bank pwm_gen_bank_chk #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN)) u_bank_chk (
    .clk     (clk),
    .rst     (rst),
    .pin_out (pin_out),
    .gen_out (gen_out),
    .gen_wrap(gen_wrap),
    .pin_map (pin_map)
);

bind pwm_wavegen pwm_wavegen_chk u_wave_chk (
    .clk     (clk),
    .rst     (rst),
    .per_l   (per_l),
    .duty_l  (duty_l),
    .step_cnt(step_cnt),
    .active  (active),
    .wrap_o  (wrap_o),
    .out_o   (out_o)
);

// File: tb/pwm_gen_bank_test.sv
`timescale 1ns/100ps
module pwm_gen_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pin_out;
    logic [7:0]  gen_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] shadow [8];

    always #2.5 clk = ~clk;

    pwm_gen_bank #(.NUM_GEN(8), .NUM_PIN(16), .BASE_DIV(1)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_out(pin_out), .gen_out(gen_out)
    );

    // period, high, low, expected high cycles, expected period cycles
    localparam int VEC [5][5] = '{
        '{  1,   3,  2,   3,   5},
        '{  2,   4,  1,   8,  10},
        '{  3,   1,  6,   3,  21},
        '{255,   1,  1, 250, 500},
        '{  1, 200, 55, 200, 255}
    };

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic smp(input int kind, input int idx);
        return (kind == 0) ? gen_out[idx] : pin_out[idx];
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        addr = 3'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_per(input int g, input int v);
        shadow[g/4][8*(g%4) +: 8] = 8'(v);
        wr(g/4, shadow[g/4]);
    endtask

    task automatic set_duty(input int g, input int hi, input int lo);
        shadow[2+g/2][16*(g%2) +: 16] = {8'(lo), 8'(hi)};
        wr(2+g/2, shadow[2+g/2]);
    endtask

    task automatic set_map(input int p, input logic en, input int id);
        shadow[6+p/8][4*(p%8) +: 4] = {en, 3'(id)};
        wr(6+p/8, shadow[6+p/8]);
    endtask

    task automatic wait_rise(input int kind, input int idx, output logic ok);
        logic prev = smp(kind, idx);
        ok = 1'b0;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (!prev && smp(kind, idx)) begin ok = 1'b1; return; end
            prev = smp(kind, idx);
        end
    endtask

    task automatic measure(input int kind, input int idx, output int hi, output int len);
        logic ok;
        logic prev;
        hi = 0; len = 0;
        wait_rise(kind, idx, ok);
        if (!ok) return;
        hi = 1; len = 1; prev = 1'b1;
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (!prev && smp(kind, idx)) return;
            if (smp(kind, idx)) hi++;
            len++;
            prev = smp(kind, idx);
        end
        len = 0;
    endtask

    task automatic count_high(input int kind, input int idx, input int cycles, output int hc);
        hc = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (smp(kind, idx)) hc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int hi, len, hc, mism;
        logic ok;
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #0.1;
            check(rdata == 32'h0, "R1 word clear", int'(rdata), 0);
        end
        check(pin_out == '0, "R1 pins low", int'(pin_out), 0);
        check(gen_out == '0, "R1 generators low", int'(gen_out), 0);

        // R3 R4 R10: table-driven waveforms on generators 0..4, each via its own pin
        for (int v = 0; v < 5; v++) begin
            set_per(v, VEC[v][0]);
            set_duty(v, VEC[v][1], VEC[v][2]);
            set_map(v, 1'b1, v);
            measure(0, v, hi, len);
            check(hi == VEC[v][3], "R3 R10 generator high time", hi, VEC[v][3]);
            check(len == VEC[v][4], "R3 R4 generator period", len, VEC[v][4]);
            measure(1, v, hi, len);
            check(hi == VEC[v][3] && len == VEC[v][4], "R8 pin follows generator", len, VEC[v][4]);
        end

        // R6: idle generator 5 (period 0, nonzero duty)
        set_duty(5, 5, 5);
        count_high(0, 5, 100, hc);
        check(hc == 0, "R6 idle generator low", hc, 0);

        // R5: zero high count then full duty on generator 7
        set_per(7, 1);
        set_duty(7, 0, 255);
        count_high(0, 7, 600, hc);
        check(hc == 0, "R5 zero duty low", hc, 0);
        set_duty(7, 255, 0);
        repeat (300) @(negedge clk);
        count_high(0, 7, 600, hc);
        check(hc == 600, "R5 full duty high", hc, 600);

        // R8: id change and enable act at once
        set_map(9, 1'b1, 7);
        check(pin_out[9] == 1'b1, "R8 enable immediate", int'(pin_out[9]), 1);
        set_map(9, 1'b1, 5);
        check(pin_out[9] == 1'b0, "R8 id change to idle gen", int'(pin_out[9]), 0);
        set_map(9, 1'b1, 7);
        check(pin_out[9] == 1'b1, "R8 id change back", int'(pin_out[9]), 1);

        // R9: never-enabled pin stays low even on a high generator
        shadow[7][4*6 +: 4] = {1'b0, 3'd7};
        wr(7, shadow[7]);
        count_high(1, 14, 50, hc);
        check(hc == 0, "R9 disabled pin low", hc, 0);

        // R7: duty rewrite mid-pulse keeps current pulse
        set_per(6, 1);
        set_duty(6, 2, 2);
        wait_rise(0, 6, ok);
        shadow[5][0 +: 16] = {8'd6, 8'd6};
        addr = 3'd5; wdata = shadow[5]; wr_en = 1'b1;
        hi = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (gen_out[6] && hi < 50) begin
            hi++;
            @(negedge clk);
        end
        check(ok && hi == 2, "R7 old pulse completes", hi, 2);
        measure(0, 6, hi, len);
        check(hi == 6 && len == 12, "R7 new shape after boundary", len, 12);

        // R9: disable waits for generator boundary
        set_map(10, 1'b1, 6);
        wait_rise(0, 6, ok);
        shadow[7][4*2 +: 4] = {1'b0, 3'd6};
        wr(7, shadow[7]);
        check(pin_out[10] == 1'b1, "R9 pin held until boundary", int'(pin_out[10]), 1);
        repeat (14) @(negedge clk);
        count_high(1, 10, 40, hc);
        check(hc == 0, "R9 pin low after boundary", hc, 0);

        // R11: two pins sharing generator 0
        set_map(12, 1'b1, 0);
        set_map(13, 1'b1, 0);
        mism = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pin_out[12] != gen_out[0] || pin_out[13] != gen_out[0]) mism++;
        end
        check(mism == 0, "R11 shared generator pins match", mism, 0);

        // R2: readback of every word
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #0.1;
            check(rdata == shadow[a], "R2 readback", int'(rdata), int'(shadow[a]));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule